// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block drives the bus-direction line of an asynchronous serial transmitter that shares a half-duplex RS-485 pair with other nodes. It watches four signals from the transmit path: the strobe that writes a byte into the transmit FIFO, the FIFO-empty flag, the busy flag of the shift register, and a 16x oversampling tick from the baud generator. From these it produces the line-driver direction output and a level-sensitive transmit-empty interrupt request.

Two control inputs set its mode. With `auto_en` set, the direction output goes to its transmitting level when a byte is written. It goes back to idle one full bit time after the stop bit of the last character, and the interrupt waits until the shift register has drained. With `auto_en` clear, the direction output stays at its idle level and the interrupt follows the legacy rule: it rises when the FIFO becomes empty, even if the shifter is still sending. `pol_inv` swaps the idle and active levels of the direction output.

The control logic is a three-state machine. In `ST_IDLE` the driver is released. In `ST_SENDING` data is queued or being shifted. In `ST_HOLDOFF` the machine counts the trailing bit time. The transitions are:
- `ST_IDLE` to `ST_SENDING` on a FIFO write in automatic mode.
- `ST_SENDING` to `ST_HOLDOFF` when the shift register's busy flag falls while the FIFO is empty and no write is present.
- `ST_HOLDOFF` to `ST_IDLE` on the 16th tick.
- `ST_HOLDOFF` to `ST_SENDING` when a write cancels the delay.
- `ST_SENDING` or `ST_HOLDOFF` to `ST_IDLE` when automatic mode is switched off.

Top module: `txdir_ctrl`

## Requirements
- R1: After reset, `dir_o` is at its idle level (1 with `pol_inv` = 0) and `txe_irq` is 0.
- R2: With `auto_en` = 1, a cycle with `fifo_wr` = 1 puts `dir_o` at the active level (0 with `pol_inv` = 0) from the next clock edge.
- R3: When `shift_busy` falls while `fifo_empty` = 1, `dir_o` stays active through the next 15 `tick16` pulses and returns to idle at the clock edge that samples the 16th pulse. Pulses are counted from the cycle after the fall.
- R4: If `shift_busy` falls while `fifo_empty` = 0, the character is not the last one. `dir_o` stays active no matter how many ticks follow.
- R5: A `fifo_wr` during the trailing delay cancels it. `dir_o` stays active, and a later delay counts a fresh 16 ticks.
- R6: With `pol_inv` = 1, the idle level is 0 and the active level is 1.
- R7: With `auto_en` = 0, `dir_o` stays at the idle level, and FIFO writes have no effect on it.
- R8: In automatic mode, `txe_irq` rises at the edge after `shift_busy` falls with `fifo_empty` = 1. A rise of `fifo_empty` while the shifter is busy does not raise it.
- R9: In legacy mode, `txe_irq` rises at the edge after `fifo_empty` goes from 0 to 1, even while `shift_busy` = 1. A falling `shift_busy` does not raise it.
- R10: `txe_irq` is 0 from the edge after any cycle with `fifo_wr` = 1 or `stat_rd` = 1. A clear wins over a set in the same cycle.
- R11: Clearing `auto_en` during a transfer returns `dir_o` to idle at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | 1 = automatic direction control and deferred interrupt |
| pol_inv | input | 1 | 1 = swap idle and active levels of `dir_o` |
| fifo_wr | input | 1 | Transmit FIFO write strobe, one cycle per byte |
| fifo_empty | input | 1 | Transmit FIFO holds no bytes |
| shift_busy | input | 1 | Transmit shift register is sending a character, including its stop bit |
| tick16 | input | 1 | One-cycle pulse, 16 per bit time |
| stat_rd | input | 1 | Host read of the interrupt status |
| dir_o | output | 1 | Line-driver direction output |
| txe_irq | output | 1 | Transmit-empty interrupt request, level |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. The output decode after the state register is combinational, so `dir_o` and `txe_irq` follow a write, a busy fall, a FIFO-empty rise, a status read or a mode change at the next edge. The end of the trailing delay appears at the edge that samples the 16th tick. The bench changes inputs on the falling clock edge and holds each pulse for exactly one rising edge. It samples the outputs at the following falling edge, which is the first point where the registered result is visible. For the delay window it checks both the 15th tick, where the output must still be active, and the 16th, where it must be idle.

// File: rtl/txdir_pkg.sv
package txdir_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SENDING = 2'd1,
        ST_HOLDOFF = 2'd2
    } dir_state_t;
endpackage

// File: rtl/txdir_edges.sv
module txdir_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_busy,
    input  logic fifo_empty,
    output logic busy_fall,
    output logic empty_rise
);
    logic busy_q;
    logic empty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            busy_q  <= shift_busy;
            empty_q <= fifo_empty;
        end
    end

    always_comb begin
        busy_fall  = busy_q & ~shift_busy;
        empty_rise = ~empty_q & fifo_empty;
    end
endmodule

// File: rtl/txdir_bitdelay.sv
module txdir_bitdelay #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end

    always_comb begin
        done = run & tick & (cnt_q == LAST);
    end

    // R3: each tick inside the window advances the count by one
    assert_tick_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CW'(1)));

    // R5: a window left early restarts from zero
    assert_window_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (cnt_q == '0));
endmodule

// File: rtl/txdir_fsm.sv
module txdir_fsm
    import txdir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_en,
    input  logic       fifo_wr,
    input  logic       fifo_empty,
    input  logic       busy_fall,
    input  logic       delay_done,
    output logic       drive_active,
    output logic       holdoff_run
);
    dir_state_t state_q;
    dir_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (auto_en && fifo_wr) state_d = ST_SENDING;
            end
            ST_SENDING: begin
                if (!auto_en)                        state_d = ST_IDLE;
                else if (fifo_wr)                    state_d = ST_SENDING;
                else if (busy_fall && fifo_empty)    state_d = ST_HOLDOFF;
            end
            ST_HOLDOFF: begin
                if (!auto_en)        state_d = ST_IDLE;
                else if (fifo_wr)    state_d = ST_SENDING;
                else if (delay_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        drive_active = (state_q != ST_IDLE);
        holdoff_run  = (state_q == ST_HOLDOFF);
    end

    // R2: a write in automatic mode always leaves the machine transmitting
    assert_write_activates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && fifo_wr) |=> (state_q == ST_SENDING));

    // R3: the last character finishing starts the trailing delay
    assert_drain_holdoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SENDING && auto_en && !fifo_wr && busy_fall && fifo_empty)
        |=> (state_q == ST_HOLDOFF));

    // R4: a busy fall with bytes still queued keeps the driver on
    assert_not_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SENDING && auto_en && !fifo_empty) |=> (state_q == ST_SENDING));

    // R11: leaving automatic mode releases the line
    assert_mode_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/txdir_irq.sv
module txdir_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic fifo_wr,
    input  logic stat_rd,
    input  logic fifo_empty,
    input  logic busy_fall,
    input  logic empty_rise,
    output logic irq
);
    logic irq_q;
    logic set_evt;
    logic clr_evt;

    always_comb begin
        set_evt = auto_en ? (busy_fall & fifo_empty) : empty_rise;
        clr_evt = fifo_wr | stat_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (clr_evt) begin
            irq_q <= 1'b0;
        end else if (set_evt) begin
            irq_q <= 1'b1;
        end
    end

    assign irq = irq_q;

    // R10: a write or status read leaves the request low
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr || stat_rd) |=> !irq_q);

    // R9: legacy mode raises on the FIFO going empty
    assert_legacy_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && empty_rise && !fifo_wr && !stat_rd) |=> irq_q);

    // R8: in automatic mode nothing but a drained shifter raises the request
    assert_auto_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !busy_fall && !irq_q) |=> !irq_q);
endmodule

// File: rtl/txdir_ctrl.sv
module txdir_ctrl #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic pol_inv,
    input  logic fifo_wr,
    input  logic fifo_empty,
    input  logic shift_busy,
    input  logic tick16,
    input  logic stat_rd,
    output logic dir_o,
    output logic txe_irq
);
    logic busy_fall;
    logic empty_rise;
    logic holdoff_run;
    logic delay_done;
    logic drive_active;

    txdir_edges u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_busy (shift_busy),
        .fifo_empty (fifo_empty),
        .busy_fall  (busy_fall),
        .empty_rise (empty_rise)
    );

    txdir_bitdelay #(.TICKS(TICKS_PER_BIT)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (holdoff_run),
        .tick  (tick16),
        .done  (delay_done)
    );

    txdir_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_en      (auto_en),
        .fifo_wr      (fifo_wr),
        .fifo_empty   (fifo_empty),
        .busy_fall    (busy_fall),
        .delay_done   (delay_done),
        .drive_active (drive_active),
        .holdoff_run  (holdoff_run)
    );

    txdir_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_en    (auto_en),
        .fifo_wr    (fifo_wr),
        .stat_rd    (stat_rd),
        .fifo_empty (fifo_empty),
        .busy_fall  (busy_fall),
        .empty_rise (empty_rise),
        .irq        (txe_irq)
    );

    // idle level is high unless the polarity is swapped
    always_comb begin
        dir_o = ~drive_active ^ pol_inv;
    end

    // R7: with automatic control off the output sits at its idle level
    assert_legacy_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en) |=> (dir_o == !pol_inv));

    // R6: the output always reflects the machine through the chosen polarity
    assert_polarity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_o == (drive_active ? pol_inv : !pol_inv)));
endmodule

// File: tb/txdir_ctrl_test.sv
`timescale 1ns/1ps
module txdir_ctrl_test;
    logic clk = 1'b0;
    logic rst_n, auto_en, pol_inv, fifo_wr, fifo_empty, shift_busy, tick16, stat_rd;
    logic dir_o, txe_irq;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    txdir_ctrl uut (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .pol_inv(pol_inv),
        .fifo_wr(fifo_wr), .fifo_empty(fifo_empty), .shift_busy(shift_busy),
        .tick16(tick16), .stat_rd(stat_rd), .dir_o(dir_o), .txe_irq(txe_irq)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick16 = 1'b1; step();
            tick16 = 1'b0; step();
        end
    endtask

    task automatic wr_byte();
        fifo_wr = 1'b1; fifo_empty = 1'b0; step();
        fifo_wr = 1'b0;
    endtask

    task automatic drain_last();
        shift_busy = 1'b1; step();
        fifo_empty = 1'b1; step();
        shift_busy = 1'b0; step();
    endtask

    task automatic clr_irq();
        stat_rd = 1'b1; step();
        stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 dir after reset", dir_o, 1'b1);
        chk("R1 irq after reset", txe_irq, 1'b0);
    endtask

    task automatic t_auto_cycle();
        auto_en = 1'b1; step();
        wr_byte();
        chk("R2 dir active after write", dir_o, 1'b0);
        shift_busy = 1'b1; step();
        fifo_empty = 1'b1; step();
        chk("R8 no irq while shifting", txe_irq, 1'b0);
        shift_busy = 1'b0; step();
        chk("R8 irq after drain", txe_irq, 1'b1);
        chk("R3 dir held at drain", dir_o, 1'b0);
        ticks(15);
        chk("R3 dir held after 15 ticks", dir_o, 1'b0);
        ticks(1);
        chk("R3 dir idle after 16 ticks", dir_o, 1'b1);
        clr_irq();
        chk("R10 irq cleared by status read", txe_irq, 1'b0);
    endtask

    task automatic t_not_last();
        wr_byte();
        shift_busy = 1'b1; step();
        shift_busy = 1'b0; step();
        chk("R4 dir held, fifo not empty", dir_o, 1'b0);
        chk("R4 no irq, fifo not empty", txe_irq, 1'b0);
        ticks(20);
        chk("R4 dir held after ticks", dir_o, 1'b0);
        drain_last();
        ticks(16);
        chk("R4 dir idle after real last", dir_o, 1'b1);
        clr_irq();
    endtask

    task automatic t_cancel();
        wr_byte();
        drain_last();
        ticks(8);
        chk("R5 dir in window", dir_o, 1'b0);
        wr_byte();
        chk("R5 dir after cancel", dir_o, 1'b0);
        chk("R10 irq cleared by write", txe_irq, 1'b0);
        ticks(10);
        chk("R5 dir stays while sending", dir_o, 1'b0);
        drain_last();
        ticks(15);
        chk("R5 fresh window held at 15", dir_o, 1'b0);
        ticks(1);
        chk("R5 fresh window ends at 16", dir_o, 1'b1);
        clr_irq();
    endtask

    task automatic t_polarity();
        pol_inv = 1'b1; step();
        chk("R6 inverted idle", dir_o, 1'b0);
        wr_byte();
        chk("R6 inverted active", dir_o, 1'b1);
        drain_last();
        ticks(16);
        chk("R6 inverted idle after delay", dir_o, 1'b0);
        pol_inv = 1'b0; step();
        clr_irq();
    endtask

    task automatic t_legacy();
        auto_en = 1'b0; step();
        wr_byte();
        chk("R7 dir idle on legacy write", dir_o, 1'b1);
        shift_busy = 1'b1; step();
        fifo_empty = 1'b1; step();
        chk("R9 irq on fifo empty while busy", txe_irq, 1'b1);
        chk("R7 dir idle in legacy", dir_o, 1'b1);
        wr_byte();
        chk("R10 irq cleared by write", txe_irq, 1'b0);
        fifo_empty = 1'b1; stat_rd = 1'b1; step();
        stat_rd = 1'b0;
        chk("R10 clear wins over set", txe_irq, 1'b0);
        shift_busy = 1'b0; step();
        chk("R9 busy fall ignored in legacy", txe_irq, 1'b0);
    endtask

    task automatic t_disable();
        auto_en = 1'b1; step();
        wr_byte();
        chk("R11 dir active before disable", dir_o, 1'b0);
        auto_en = 1'b0; step();
        chk("R11 dir idle after disable", dir_o, 1'b1);
        fifo_empty = 1'b1; step();
    endtask

    initial begin
        rst_n = 1'b0; auto_en = 1'b0; pol_inv = 1'b0; fifo_wr = 1'b0;
        fifo_empty = 1'b1; shift_busy = 1'b0; tick16 = 1'b0; stat_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_auto_cycle();
        t_not_last();
        t_cancel();
        t_polarity();
        t_legacy();
        t_disable();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule